// File: doc/BRIEF.md
# Audio Sample Pacer with Seconds Clock

This block turns a fixed system clock into a steady audio sample cadence and keeps a seconds-resolution time-of-day counter. A run/hold control bit gates all pacing. While running, a fractional accumulator adds the sample rate into a sum once per clock, modulo the clock frequency. Each time the sum wraps, a one-cycle sample strobe goes out. Over one second of running this gives exactly the sample rate in strobes. A second accumulator counts clocks up to one second. At each wrap it advances a 32-bit seconds counter. That counter starts from a fixed non-zero epoch at reset.

Control is a two-state machine. `ST_HOLD` is the reset state. In it the strobe is quiet and the seconds counter is frozen. A control write with bit 0 equal to 0 takes the transition `HOLD->RUN`, which also clears both accumulators, so the pacing restarts from phase zero. In `ST_RUN` a control write with bit 0 equal to 1 takes the transition `RUN->HOLD`. Any other write leaves the state as it is, including a write of 0 while already running. The seconds counter is read over the register port as two 16-bit halves. Writes aimed at those halves are discarded.

Register map (16-bit data, 2-bit address): address 0 is control, with bit 0 as hold. Address 1 returns counter bits 31..16 and address 2 returns bits 15..0. Address 3 reads as zero.

Top module: `sample_pacer_rtc`

## Requirements
- R1: After reset the block is in `ST_HOLD`. `sample_strobe` is 0, address 0 reads 0x0001, and addresses 1 and 2 read the upper and lower halves of `RTC_EPOCH` (0x5BFC and 0x8900 by default).
- R2: While held, `sample_strobe` stays 0 and the seconds counter does not change. The clock edge that takes a write of 1 to bit 0 already counts as held.
- R3: A write of 0 to control bit 0 while held clears both accumulators on that edge. Let that edge be edge 0 and number the following edges k = 1, 2, …. Then the counter reaches epoch+1 exactly at edge `CLK_HZ`, whatever phase the pacing had before the hold.
- R4: While running, `sample_strobe` is high in the cycle after edge k exactly when floor(k·SAMPLE_HZ/CLK_HZ) exceeds floor((k−1)·SAMPLE_HZ/CLK_HZ). This gives exactly `SAMPLE_HZ` strobes per `CLK_HZ` running cycles.
- R5: While running, the seconds counter rises by exactly one at every `CLK_HZ`-th edge since the restart. It never changes by any other amount.
- R6: Address 1 returns counter bits 31..16, address 2 returns bits 15..0, and address 3 returns 0. Reads are combinational from `rd_addr`.
- R7: Writes to addresses 1 and 2 have no effect on the counter or on the pacing.
- R8: A write of 0 to control bit 0 while already running does not restart or disturb the pacing.
- R9: Address 0 reads back the hold state in bit 0: 1 when held, 0 when running. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| sample_strobe | output | 1 | One-cycle sample pulse |

## Verification
The hardest case to reach from the ports is a restart from a non-zero pacing phase. The accumulators must be left part-way through a second and then held, and the next run must be shown to begin from zero rather than from the old phase. The stimulus runs 60 cycles with a small `CLK_HZ` (100) and holds. It then runs again and checks every cycle against the closed-form strobe rule and the seconds count. The counter must step only 100 edges after the second start, not 40. A long sweep over several seconds also writes 0 to control while running and writes to both counter halves mid-sweep, and checks that the per-cycle pattern does not shift.

// File: rtl/spr_pkg.sv
package spr_pkg;
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } spr_state_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_RTC_HI = 1;
    localparam int unsigned REG_RTC_LO = 2;
endpackage

// File: rtl/spr_rate_acc.sv
module spr_rate_acc #(
    parameter int unsigned INC = 1,
    parameter int unsigned MOD = 100,
    localparam int unsigned W  = $clog2(MOD) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic         tick,
    output logic [W-1:0] acc
);
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;

    generate
        if (INC == 1) begin : g_counter
            assign sum  = acc_q + W'(1);
            assign tick = en && (acc_q == W'(MOD - 1));
        end else begin : g_fraction
            assign sum  = acc_q + W'(INC);
            assign tick = en && (sum >= W'(MOD));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= tick ? (sum - W'(MOD)) : sum;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/spr_rtc.sv
module spr_rtc #(
    parameter int unsigned  W     = 32,
    parameter logic [W-1:0] EPOCH = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= EPOCH;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/spr_bus_if.sv
module spr_bus_if
    import spr_pkg::*;
#(
    parameter int unsigned AW = 2,
    parameter int unsigned DW = 16,
    localparam int unsigned CW = 2 * DW
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          hold,
    input  logic [CW-1:0] rtc,
    output logic          ctrl_wr,
    output logic          ctrl_bit,
    output logic [DW-1:0] rd_data
);
    assign ctrl_wr  = wr_en && (wr_addr == AW'(REG_CTRL));
    assign ctrl_bit = wr_data[0];

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(REG_CTRL)) begin
            rd_data = {{(DW-1){1'b0}}, hold};
        end else if (rd_addr == AW'(REG_RTC_HI)) begin
            rd_data = rtc[CW-1:DW];
        end else if (rd_addr == AW'(REG_RTC_LO)) begin
            rd_data = rtc[DW-1:0];
        end
    end
endmodule

// File: rtl/sample_pacer_rtc.sv
module sample_pacer_rtc
    import spr_pkg::*;
#(
    parameter int unsigned   CLK_HZ    = 50_000_000,
    parameter int unsigned   SAMPLE_HZ = 44_100,
    parameter logic [31:0]   RTC_EPOCH = 32'h5BFC_8900,
    parameter int unsigned   AW        = 2,
    parameter int unsigned   DW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sample_strobe
);
    localparam int unsigned CW    = 2 * DW;
    localparam int unsigned ACC_W = $clog2(CLK_HZ) + 1;

    spr_state_e       state_q, state_d;
    logic             ctrl_wr, ctrl_bit;
    logic             run_en, restart;
    logic             samp_tick, sec_tick;
    logic [ACC_W-1:0] samp_acc, sec_acc;
    logic [CW-1:0]    rtc_val;
    logic             strobe_q;

    spr_bus_if #(.AW(AW), .DW(DW)) u_bus (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .hold    (state_q == ST_HOLD),
        .rtc     (rtc_val),
        .ctrl_wr (ctrl_wr),
        .ctrl_bit(ctrl_bit),
        .rd_data (rd_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: HOLD->RUN on a run write, RUN->HOLD on a hold write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (ctrl_wr && !ctrl_bit) state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr &&  ctrl_bit) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run_en  = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_HOLD: restart = ctrl_wr && !ctrl_bit;
            ST_RUN:  run_en  = !(ctrl_wr && ctrl_bit);
            default: ;
        endcase
    end

    spr_rate_acc #(.INC(SAMPLE_HZ), .MOD(CLK_HZ)) u_samp_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .en   (run_en),
        .tick (samp_tick),
        .acc  (samp_acc)
    );

    spr_rate_acc #(.INC(1), .MOD(CLK_HZ)) u_sec_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .en   (run_en),
        .tick (sec_tick),
        .acc  (sec_acc)
    );

    spr_rtc #(.W(CW), .EPOCH(RTC_EPOCH)) u_rtc (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (sec_tick),
        .value(rtc_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= samp_tick;
        end
    end

    assign sample_strobe = strobe_q;
endmodule

// File: rtl/spr_checker.sv
module spr_checker
    import spr_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100,
    parameter int unsigned ACC_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input spr_state_e       state_q,
    input logic             ctrl_wr,
    input logic             ctrl_bit,
    input logic [ACC_W-1:0] samp_acc,
    input logic [ACC_W-1:0] sec_acc,
    input logic [31:0]      rtc_val,
    input logic             sample_strobe
);
    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !sample_strobe);

    assert_hold_rtc_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(rtc_val));

    assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && ctrl_wr && !ctrl_bit) |=>
            (samp_acc == '0 && sec_acc == '0 && state_q == ST_RUN));

    assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_acc < ACC_W'(CLK_HZ)) && (sec_acc < ACC_W'(CLK_HZ)));

    assert_rtc_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rtc_val) |-> (rtc_val == $past(rtc_val) + 32'd1));

    assert_rtc_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(ctrl_wr && ctrl_bit) && sec_acc == ACC_W'(CLK_HZ - 1))
            |=> (rtc_val == $past(rtc_val) + 32'd1));
endmodule

bind sample_pacer_rtc spr_checker #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .ctrl_wr      (ctrl_wr),
    .ctrl_bit     (ctrl_bit),
    .samp_acc     (samp_acc),
    .sec_acc      (sec_acc),
    .rtc_val      (rtc_val),
    .sample_strobe(sample_strobe)
);

// File: tb/sample_pacer_rtc_tb.sv
`timescale 1ns/1ps
module sample_pacer_rtc_tb;
    localparam int unsigned CLK_HZ = 100;
    localparam int unsigned RATE   = 7;
    localparam logic [31:0] EPOCH  = 32'h5BFC_8900;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        sample_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sample_pacer_rtc #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(RATE), .RTC_EPOCH(EPOCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sample_strobe(sample_strobe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hold_watch(input int n, input logic [31:0] rtc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R2 strobe quiet", {31'h0, sample_strobe}, 32'h0);
        end
        read_chk("R2 rtc hi frozen", 2'd1, rtc[31:16]);
        read_chk("R2 rtc lo frozen", 2'd2, rtc[15:0]);
    endtask

    // Entered at the negedge just after the run-write edge (edge 0)
    task automatic run_sweep(input int n, input logic [31:0] base, input bit inject);
        int cnt = 0;
        for (int k = 1; k <= n; k++) begin
            if (inject && k == 150) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000; end
            if (inject && k == 170) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0000; end
            if (inject && k == 171) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'hFFFF; end
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0;
            begin
                logic exp_s;
                logic [31:0] exp_rtc;
                exp_s = ((k * RATE) / CLK_HZ) != (((k - 1) * RATE) / CLK_HZ);
                exp_rtc = base + 32'(k / CLK_HZ);
                if (sample_strobe) cnt++;
                check(inject ? "R4/R8 strobe pattern" : "R3/R4 strobe pattern",
                      {31'h0, sample_strobe}, {31'h0, exp_s});
                read_chk(inject ? "R5/R7 rtc lo" : "R3/R5 rtc lo", 2'd2, exp_rtc[15:0]);
                if (k % CLK_HZ == 0) begin
                    check("R4 strobes per second", cnt, RATE);
                    cnt = 0;
                    read_chk("R5/R6 rtc hi", 2'd1, exp_rtc[31:16]);
                end
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 strobe low", {31'h0, sample_strobe}, 32'h0);
        read_chk("R1 ctrl held", 2'd0, 16'h0001);
        read_chk("R1 epoch hi", 2'd1, EPOCH[31:16]);
        read_chk("R1 epoch lo", 2'd2, EPOCH[15:0]);
        read_chk("R6 unmapped zero", 2'd3, 16'h0000);
        hold_watch(40, EPOCH);
        // R7 while held too
        write_reg(2'd2, 16'h1234);
        read_chk("R7 lo write ignored", 2'd2, EPOCH[15:0]);
        // Long run with mid-sweep writes
        write_reg(2'd0, 16'h0000);
        read_chk("R9 ctrl running", 2'd0, 16'h0000);
        run_sweep(300, EPOCH, 1'b1);
        write_reg(2'd0, 16'h0001);
        read_chk("R9 ctrl held", 2'd0, 16'h0001);
        hold_watch(50, EPOCH + 32'd3);
        // Partial second, hold, restart from zero phase
        write_reg(2'd0, 16'h0000);
        run_sweep(60, EPOCH + 32'd3, 1'b0);
        write_reg(2'd0, 16'h0001);
        hold_watch(10, EPOCH + 32'd3);
        write_reg(2'd0, 16'h0000);
        run_sweep(150, EPOCH + 32'd3, 1'b0);
        read_chk("R3 restart rtc hi", 2'd1, (EPOCH[31:0] + 32'd4) >> 16);
        read_chk("R3 restart rtc lo", 2'd2, 16'(EPOCH + 32'd4));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule